// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 64-bit virtual address into a physical address by way of a single-level page table in memory. Pages are 8 KiB, so the low 13 bits of an address pass through unchanged as the in-page offset. The bits above them form the virtual page number. That number selects an 8-byte table entry at a programmable table base. The block fetches the entry through a read port with a request/response handshake whose latency may vary. It then checks the entry for validity, for the privilege mode of the access, and for the type of the access. It answers with either a physical address or a fault with a reason code.

Addresses whose top 22 bits are all ones (0xfffffc0000000000 and up) form a directly mapped kernel segment. Such addresses never touch the table. In kernel mode they map to the address minus the segment base. In user mode they fault at once. The block works on one translation at a time: a new request is only taken once the previous answer has been given.

Top module: `paged_xlate_unit`

## Requirements
- R1: For a valid, permitted entry, the physical address is the entry's frame number (entry bits 63:32) times 8192 plus the low 13 bits of the virtual address. For example, 0x2194 with page 1 mapped to frame 4 gives 0x8194.
- R2: The entry read address is the table base plus eight times the virtual page number (virtual address bits 63:13). The table base is loaded from `base_wdata` in any cycle where `base_we` is high.
- R3: An entry with bit 0 clear gives a fault with cause 1 and a physical address of zero.
- R4: Access type 1 is a write, 2 is an execute, and 0 or 3 is a read. Reads and executes need the read enable of the current mode: entry bit 8 for kernel, bit 9 for user. Writes need the write enable: bit 10 for kernel, bit 11 for user. A missing enable gives cause 2.
- R5: A read with entry bit 1 set gives cause 3. A write with bit 2 set gives cause 4. An execute with bit 3 set gives cause 5.
- R6: When several faults apply, the cause follows this order: kernel-segment violation, then invalid entry (1), then missing enable (2), then the fault-on bit for the access type (3/4/5).
- R7: A kernel-segment address issues no memory read. In kernel mode it returns the address minus 0xfffffc0000000000 for any access type. In user mode it gives cause 6 and a physical address of zero.
- R8: Only one translation is in flight. `req_ready` stays low from acceptance until the response cycle has passed. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. Any read latency of one cycle or more is accepted.
- R9: `rsp_valid` is a single-cycle pulse. `rsp_fault` is high exactly when `rsp_cause` is nonzero (0 means no fault). `rsp_vaddr` returns the translated virtual address.
- R10: After reset, `req_ready` is high and `mem_req_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load table base |
| base_wdata | input | 64 | Table base value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready for a request |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Entry read request accepted |
| mem_req_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_paddr | output | 64 | Physical address, zero on fault |
| rsp_fault | output | 1 | Fault flag |
| rsp_cause | output | 3 | Fault reason code |
| rsp_vaddr | output | 64 | Virtual address of this result |

## Verification
Some properties are checked by assertions on every cycle:
- the read request is held stable until it is accepted;
- requests are refused while a translation is busy;
- the response is a one-cycle pulse, and the fault flag agrees with the cause;
- a faulting response carries a zero address;
- a clean response keeps the page offset;
- a kernel-segment request answers in the next cycle without a memory read.

The bench scenarios cover what a per-cycle rule cannot express: the entry address arithmetic, the mapping from frame number to physical address, the decode of each enable and fault-on bit per mode and access type, and the priority among overlapping faults. These are checked against a model, under random read-port stalls and random latencies.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WAIT  = 2'd2,
    S_RESP  = 2'd3
  } xlate_state_e;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [2:0] C_NONE    = 3'd0;
  localparam logic [2:0] C_INVALID = 3'd1;
  localparam logic [2:0] C_DENIED  = 3'd2;
  localparam logic [2:0] C_NO_RD   = 3'd3;
  localparam logic [2:0] C_NO_WR   = 3'd4;
  localparam logic [2:0] C_NO_EX   = 3'd5;
  localparam logic [2:0] C_KSEG    = 3'd6;

  localparam int B_VALID = 0;
  localparam int B_FO_RD = 1;
  localparam int B_FO_WR = 2;
  localparam int B_FO_EX = 3;
  localparam int B_K_RD  = 8;
  localparam int B_U_RD  = 9;
  localparam int B_K_WR  = 10;
  localparam int B_U_WR  = 11;
endpackage

// File: rtl/xlate_split.sv
module xlate_split #(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int PTE_LG2   = 3,
  parameter int KSEG_BITS = 22
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [VA_W-1:0] base,
  output logic [VA_W-1:0] entry_addr,
  output logic            kseg_hit,
  output logic [VA_W-1:0] kseg_pa
);
  localparam int LOW_W = VA_W - KSEG_BITS;

  logic [VA_W-1:0] vpn;

  always_comb begin
    vpn        = vaddr >> PAGE_BITS;
    entry_addr = base + (vpn << PTE_LG2);
    kseg_hit   = &vaddr[VA_W-1:LOW_W];
    // inside the segment, removing the base is the same as clearing the top bits
    kseg_pa    = {{KSEG_BITS{1'b0}}, vaddr[LOW_W-1:0]};
  end
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int PFN_LSB   = 32
) (
  input  logic [VA_W-1:0]      pte,
  input  logic [1:0]           acc,
  input  logic                 user,
  input  logic [PAGE_BITS-1:0] offset,
  output logic                 fault,
  output logic [2:0]           cause,
  output logic [VA_W-1:0]      paddr
);
  localparam int PFN_W = VA_W - PFN_LSB;

  logic            is_wr, is_ex, is_rd, enabled;
  logic [VA_W-1:0] pfn_ext;
  logic            unused_pte;

  assign unused_pte = ^{pte[PFN_LSB-1:B_U_WR+1], pte[B_K_RD-1:B_FO_EX+1]};

  always_comb begin
    is_wr   = (acc == ACC_WRITE);
    is_ex   = (acc == ACC_EXEC);
    is_rd   = !is_wr && !is_ex;
    enabled = is_wr ? (user ? pte[B_U_WR] : pte[B_K_WR])
                    : (user ? pte[B_U_RD] : pte[B_K_RD]);
    pfn_ext = {{PFN_LSB{1'b0}}, pte[VA_W-1:VA_W-PFN_W]};

    cause = C_NONE;
    if (!pte[B_VALID])                 cause = C_INVALID;
    else if (!enabled)                 cause = C_DENIED;
    else if (is_ex && pte[B_FO_EX])    cause = C_NO_EX;
    else if (is_wr && pte[B_FO_WR])    cause = C_NO_WR;
    else if (is_rd && pte[B_FO_RD])    cause = C_NO_RD;

    fault = (cause != C_NONE);
    paddr = fault ? '0 : ((pfn_ext << PAGE_BITS) | {{(VA_W-PAGE_BITS){1'b0}}, offset});
  end
endmodule

// File: rtl/paged_xlate_unit.sv
module paged_xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int PTE_LG2   = 3,
  parameter int KSEG_BITS = 22,
  parameter int PFN_LSB   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_we,
  input  logic [VA_W-1:0] base_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic            req_user,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic [2:0]      rsp_cause,
  output logic [VA_W-1:0] rsp_vaddr
);
  localparam int KSEG_LSB = VA_W - KSEG_BITS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  xlate_state_e    state_q, state_d;
  logic [VA_W-1:0] base_q, va_q, ea_q, pa_q;
  logic [1:0]      acc_q;
  logic            user_q, fault_q;
  logic [2:0]      cause_q;

  logic            ld_req, ld_res;
  logic            res_fault_d;
  logic [2:0]      res_cause_d;
  logic [VA_W-1:0] res_pa_d;

  logic [VA_W-1:0] ea_d, kseg_pa;
  logic            kseg_hit;
  logic            chk_fault;
  logic [2:0]      chk_cause;
  logic [VA_W-1:0] chk_pa;

  xlate_split #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PTE_LG2(PTE_LG2), .KSEG_BITS(KSEG_BITS)
  ) u_split (
    .vaddr(req_vaddr), .base(base_q), .entry_addr(ea_d),
    .kseg_hit(kseg_hit), .kseg_pa(kseg_pa)
  );

  xlate_perm #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PFN_LSB(PFN_LSB)
  ) u_perm (
    .pte(mem_rsp_data), .acc(acc_q), .user(user_q),
    .offset(va_q[PAGE_BITS-1:0]),
    .fault(chk_fault), .cause(chk_cause), .paddr(chk_pa)
  );

  always_comb begin
    state_d     = state_q;
    ld_req      = 1'b0;
    ld_res      = 1'b0;
    res_fault_d = 1'b0;
    res_cause_d = C_NONE;
    res_pa_d    = '0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        ld_req = 1'b1;
        if (kseg_hit) begin
          ld_res      = 1'b1;
          res_fault_d = req_user;
          res_cause_d = req_user ? C_KSEG : C_NONE;
          res_pa_d    = req_user ? '0 : kseg_pa;
          state_d     = S_RESP;
        end else begin
          state_d = S_FETCH;
        end
      end
      S_FETCH: if (mem_req_ready) state_d = S_WAIT;
      S_WAIT: if (mem_rsp_valid) begin
        ld_res      = 1'b1;
        res_fault_d = chk_fault;
        res_cause_d = chk_cause;
        res_pa_d    = chk_pa;
        state_d     = S_RESP;
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (base_we) base_q <= base_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      va_q   <= req_vaddr;
      acc_q  <= req_acc;
      user_q <= req_user;
      ea_q   <= ea_d;
    end
    if (ld_res) begin
      fault_q <= res_fault_d;
      cause_q <= res_cause_d;
      pa_q    <= res_pa_d;
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_FETCH);
  assign mem_req_addr  = ea_q;
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_vaddr     = va_q;

  p_memreq_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req_valid || rsp_valid) |-> !req_ready);
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid |=> !rsp_valid);
  p_fault_flag_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != C_NONE)));
  p_fault_zero_pa_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);
  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_BITS-1:0] == rsp_vaddr[PAGE_BITS-1:0]);
  p_kseg_direct_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid && req_ready && (&req_vaddr[VA_W-1:KSEG_LSB]) |=> rsp_valid && !mem_req_valid);
endmodule

// File: tb/sim_paged_xlate_unit.sv
`timescale 1ns/1ps
module sim_paged_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_we;
  logic [63:0] base_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic [63:0] rsp_paddr;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic [63:0] rsp_vaddr;

  int checks = 0;
  int failures = 0;
  logic [63:0] base_m;
  logic        ovr_en;
  logic [63:0] ovr_addr, ovr_pte;

  always #2 clk = ~clk;

  paged_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_vaddr(rsp_vaddr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] pte_of(input logic [63:0] a);
    logic [63:0] h;
    if (ovr_en && a == ovr_addr) return ovr_pte;
    h = a * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 29);
    return {h[63:32], 20'h0, h[11:8] | h[21:18], 4'h0, h[14:12] & h[17:15], h[2:0] != 3'd0};
  endfunction

  // returns {fault, cause, paddr}
  function automatic logic [67:0] model(input logic [63:0] va, input logic [1:0] acc,
                                        input logic user, input logic [63:0] pte);
    logic en;
    if (&va[63:42]) begin
      if (user) return {1'b1, 3'd6, 64'd0};
      return {1'b0, 3'd0, va - 64'hfffffc0000000000};
    end
    if (!pte[0]) return {1'b1, 3'd1, 64'd0};
    en = (acc == 2'd1) ? (user ? pte[11] : pte[10]) : (user ? pte[9] : pte[8]);
    if (!en) return {1'b1, 3'd2, 64'd0};
    if (acc == 2'd2 && pte[3]) return {1'b1, 3'd5, 64'd0};
    if (acc == 2'd1 && pte[2]) return {1'b1, 3'd4, 64'd0};
    if ((acc == 2'd0 || acc == 2'd3) && pte[1]) return {1'b1, 3'd3, 64'd0};
    return {1'b0, 3'd0, ({32'd0, pte[63:32]} * 64'd8192) + {51'd0, va[12:0]}};
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd6: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic set_base(input logic [63:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    base_m = b;
  endtask

  task automatic run_one(input logic [63:0] va, input logic [1:0] acc, input logic user, input string tg);
    logic [63:0] ea, pte;
    logic [67:0] e;
    int seen = 0;
    int cnt = -1;
    bit got = 0;
    string t;
    ea  = base_m + ((va >> 13) << 3);
    pte = pte_of(ea);
    e   = model(va, acc, user, pte);
    t   = (tg == "") ? tag_of(e[66:64]) : tg;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      mem_rsp_valid = 1'b0;
      if (rsp_valid) begin
        got = 1;
        chk(rsp_fault == e[67], t, {63'd0, rsp_fault}, {63'd0, e[67]});
        chk(rsp_cause == e[66:64], t, {61'd0, rsp_cause}, {61'd0, e[66:64]});
        chk(rsp_paddr == e[63:0], t, rsp_paddr, e[63:0]);
        chk(rsp_vaddr == va, "R9 vaddr", rsp_vaddr, va);
      end else begin
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = pte; cnt = -1;
          end
        end
        if (mem_req_valid) begin
          seen++;
          if (seen == 1) begin
            chk(mem_req_addr == ea, "R2 entry address", mem_req_addr, ea);
            chk(!req_ready, "R8 busy refuses", {63'd0, req_ready}, 64'd0);
          end
          mem_req_ready = 1'($urandom % 2);
          if (mem_req_ready) cnt = 1 + int'($urandom % 4);
        end else begin
          mem_req_ready = 1'b0;
        end
        @(negedge clk);
      end
    end
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    if (!got) chk(1'b0, "R8 no response", 64'd0, 64'd1);
    if (&va[63:42]) chk(seen == 0, "R7 no memory read", 64'(seen), 64'd0);
    @(negedge clk);
    chk(!rsp_valid, "R9 single pulse", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic directed(input logic [63:0] va, input logic [1:0] acc, input logic user,
                          input logic [63:0] pte, input string tg);
    ovr_en = 1'b1;
    ovr_addr = base_m + ((va >> 13) << 3);
    ovr_pte = pte;
    run_one(va, acc, user, tg);
    ovr_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; base_we = 1'b0; base_wdata = '0; req_valid = 1'b0;
    req_vaddr = '0; req_acc = '0; req_user = 1'b0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; ovr_en = 1'b0; ovr_addr = '0; ovr_pte = '0;
    base_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R10 ready", {63'd0, req_ready}, 64'd1);
    chk(!mem_req_valid, "R10 mem idle", {63'd0, mem_req_valid}, 64'd0);
    chk(!rsp_valid, "R10 no response", {63'd0, rsp_valid}, 64'd0);

    set_base(64'h0000_0000_1000_0000);
    // worked example: page 1 -> frame 4, kernel read enable
    directed(64'h2194, 2'd0, 1'b0, {32'd4, 20'h0, 4'b0001, 4'h0, 4'b0001}, "R1");
    directed(64'h2194, 2'd0, 1'b0, {32'd4, 20'h0, 4'b1111, 4'h0, 4'b1110}, "R3");
    directed(64'h4000, 2'd1, 1'b1, {32'd9, 20'h0, 4'b0111, 4'h0, 4'b0001}, "R4");
    directed(64'h4000, 2'd2, 1'b1, {32'd9, 20'h0, 4'b1101, 4'h0, 4'b0001}, "R4");
    directed(64'h6123, 2'd3, 1'b0, {32'd7, 20'h0, 4'b1111, 4'h0, 4'b0011}, "R5");
    directed(64'h6123, 2'd1, 1'b0, {32'd7, 20'h0, 4'b1111, 4'h0, 4'b0101}, "R5");
    directed(64'h6123, 2'd2, 1'b1, {32'd7, 20'h0, 4'b1111, 4'h0, 4'b1001}, "R5");
    directed(64'h6123, 2'd1, 1'b0, {32'd7, 20'h0, 4'b1011, 4'h0, 4'b1011}, "R6");
    directed(64'h6123, 2'd2, 1'b0, {32'd7, 20'h0, 4'b1111, 4'h0, 4'b1110}, "R6");
    run_one(64'hffff_fc00_0031_0000, 2'd2, 1'b0, "R7");
    run_one(64'hffff_ffff_ffff_fff8, 2'd1, 1'b0, "R7");
    run_one(64'hffff_fc00_0031_0000, 2'd0, 1'b1, "R6");
    set_base(64'h0000_00ab_cd00_0000);
    directed(64'h0000_0000_3fff_ffff, 2'd0, 1'b1, {32'hffff_ffff, 20'h0, 4'b0010, 4'h0, 4'b0001}, "R1");

    for (int n = 0; n < 400; n++) begin
      logic [63:0] va;
      va = {$urandom, $urandom};
      if ($urandom % 8 == 0) va[63:42] = '1;
      else va[63:40] = 24'($urandom % 4);
      if (n == 200) set_base({$urandom, $urandom} & 64'h0000_ffff_ffff_fff8);
      run_one(va, 2'($urandom % 4), 1'($urandom % 2), "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule